// File: doc/BRIEF.md
# Little-Endian Byte and Doubleword Load-Store Unit

This unit sits between a 64-bit register datapath and a byte-addressed data store. Each request carries a base address, a 9-bit signed displacement, a 64-bit store value and an access kind. The unit adds the base and the sign-extended displacement to form the effective address. It then steers the access onto a 64-bit memory row that has one write enable per byte lane, and returns load data aligned to bit 0 of the register.

Byte lanes follow little-endian order. The lowest byte address of a row holds bits [7:0] of that row. Byte accesses choose their lane with effective-address bits [2:0]. Doubleword accesses must be aligned. A misaligned doubleword access is reported as an error and never changes memory. The storage is an internal synchronous RAM of `DEPTH_WORDS` rows. Row selection takes the effective address modulo the array size, so addresses past the end wrap around.

Top module: `lsu_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid`, `rsp_err` and `rsp_data` are all zero.
- R2: The effective address is `base + sign_extend(disp)`, with `disp` a 9-bit two's-complement value (-256..255). The row selected is bits [log2(DEPTH_WORDS)+2:3] of that address, so addresses wrap modulo 8*DEPTH_WORDS bytes.
- R3: `req_kind` encodes the access: 2'b00 byte load, 2'b01 byte store, 2'b10 doubleword load, 2'b11 doubleword store. Bit 1 selects doubleword size and bit 0 selects a write. An aligned doubleword store followed by a doubleword load of the same address returns the stored value.
- R4: Byte order is little-endian: the byte at effective address A+k of an aligned row is bits [8k+7:8k] of that row. A byte load returns that byte zero-extended to 64 bits.
- R5: A byte store writes `wdata[7:0]` into the one lane selected by address bits [2:0] and leaves the other seven bytes of the row unchanged.
- R6: A doubleword access whose effective-address bits [2:0] are not zero sets `rsp_err` in its response cycle, returns zero data and does not modify memory.
- R7: Every request produces exactly one response cycle (`rsp_valid` high) on the clock after it is accepted. Idle cycles produce no response.
- R8: A byte access never raises `rsp_err`, whatever lane it selects.
- R9: The response to a store, aligned or not, carries `rsp_data` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind: bit 1 doubleword size, bit 0 write |
| base | input | ADDR_W | Base address from the register file |
| disp | input | DISP_W | Signed displacement |
| wdata | input | 64 | Store value (byte stores use bits [7:0]) |
| rsp_valid | output | 1 | Response cycle, one clock after the request |
| rsp_err | output | 1 | Misaligned doubleword access |
| rsp_data | output | 64 | Load result aligned to bit 0, zero for stores and errors |

## Verification
The bench builds the unit with `DEPTH_WORDS` set to 16, which gives a 128-byte array. At that size an effective address of 0x100, reached with the largest positive displacement, wraps onto row 0. This lets the modulo row selection be checked next to data stored through the ordinary path. The most negative displacement of -256 is applied from a base of 0x140 so that it lands back on a known row. `ADDR_W` keeps its 64-bit default, so the sign-extension path runs at full width.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        KIND_LDB = 2'b00,
        KIND_STB = 2'b01,
        KIND_LDD = 2'b10,
        KIND_STD = 2'b11
    } lsu_kind_e;

    localparam int LANES  = 8;
    localparam int LANE_W = 3;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic              load;
        logic              dword;
        logic [LANE_W-1:0] lane;
    } lsu_rsp_state_t;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 9,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic              is_dword,
    output logic [IDX_W-1:0]  row_idx,
    output logic [2:0]        lane,
    output logic              misalign
);
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] eff_addr;

    always_comb begin
        disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        eff_addr = base + disp_ext;
        row_idx  = eff_addr[IDX_W+2:3];
        lane     = eff_addr[2:0];
        misalign = is_dword && (eff_addr[2:0] != 3'd0);
    end
endmodule

// File: rtl/lsu_bytemem.sv
module lsu_bytemem #(
    parameter int DEPTH = 512,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic             rd_en,
    input  logic [7:0]       wr_en,
    input  logic [63:0]      wr_row,
    output logic [63:0]      rd_row
);
    for (genvar g = 0; g < 8; g++) begin : g_lane
        logic [7:0] cells [DEPTH];
        logic [7:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                cells[idx] <= wr_row[8*g +: 8];
            end
            if (rd_en) begin
                rd_q <= cells[idx];
            end
        end

        assign rd_row[8*g +: 8] = rd_q;
    end
endmodule

// File: rtl/lsu_lane_extract.sv
module lsu_lane_extract (
    input  logic [63:0] row,
    input  logic        dword,
    input  logic [2:0]  lane,
    output logic [63:0] value
);
    logic [7:0] picked;

    always_comb begin
        picked = row[8*lane +: 8];
        value  = dword ? row : {56'd0, picked};
    end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit #(
    parameter int ADDR_W      = 64,
    parameter int DISP_W      = 9,
    parameter int DEPTH_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [63:0]       wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_data
);
    import lsu_pkg::*;

    localparam int IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;

    logic [IDX_W-1:0] row_idx;
    logic [2:0]       lane;
    logic             misalign;
    logic             is_dword;
    logic             is_write;
    logic [7:0]       wr_en;
    logic [63:0]      wr_row;
    logic             rd_en;
    logic [63:0]      rd_row;
    logic [63:0]      steered;

    lsu_rsp_state_t state_d, state_q;

    assign is_dword = req_kind[1];
    assign is_write = req_kind[0];

    lsu_agen #(
        .ADDR_W(ADDR_W),
        .DISP_W(DISP_W),
        .IDX_W (IDX_W)
    ) u_agen (
        .base    (base),
        .disp    (disp),
        .is_dword(is_dword),
        .row_idx (row_idx),
        .lane    (lane),
        .misalign(misalign)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        state_d.err   = req_valid && misalign;
        state_d.load  = req_valid && !is_write;
        state_d.dword = is_dword;
        state_d.lane  = lane;

        wr_en  = 8'd0;
        wr_row = is_dword ? wdata : {8{wdata[7:0]}};
        if (req_valid && is_write && !misalign) begin
            wr_en = is_dword ? 8'hFF : (8'd1 << lane);
        end
        rd_en = req_valid && !is_write && !misalign;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    lsu_bytemem #(
        .DEPTH(DEPTH_WORDS),
        .IDX_W(IDX_W)
    ) u_mem (
        .clk   (clk),
        .idx   (row_idx),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .wr_row(wr_row),
        .rd_row(rd_row)
    );

    lsu_lane_extract u_extract (
        .row  (rd_row),
        .dword(state_q.dword),
        .lane (state_q.lane),
        .value(steered)
    );

    assign rsp_valid = state_q.valid;
    assign rsp_err   = state_q.err;
    assign rsp_data  = (state_q.valid && state_q.load && !state_q.err) ? steered : 64'd0;

endmodule

// File: rtl/lsu_unit_chk.sv
module lsu_unit_chk #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] base,
    input logic [DISP_W-1:0] disp,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_data
);
    logic [2:0] low_sum;
    logic       odd_dword;

    assign low_sum   = base[2:0] + disp[2:0];
    assign odd_dword = req_kind[1] && (low_sum != 3'd0);

    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R6
    misalign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err == $past(odd_dword)));

    // R8
    byte_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(!req_kind[1])) |-> !rsp_err);

    // R4
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind == 2'b00)) |-> (rsp_data[63:8] == 56'd0));

    // R9
    store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind[0])) |-> (rsp_data == 64'd0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_err && rsp_data == 64'd0));
endmodule

bind lsu_unit lsu_unit_chk #(
    .ADDR_W(ADDR_W),
    .DISP_W(DISP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .base     (base),
    .disp     (disp),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_data (rsp_data)
);

// File: tb/lsu_unit_bench.sv
module lsu_unit_bench;
    localparam int AW = 64;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] base = '0;
    logic [DW-1:0] disp = '0;
    logic [63:0]   wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [63:0]   rsp_data;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    logic        got_v;
    logic        got_e;
    logic [63:0] got_d;

    localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

    always #10 clk = ~clk;

    lsu_unit #(.ADDR_W(AW), .DISP_W(DW), .DEPTH_WORDS(16)) u_lsu_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .base(base), .disp(disp), .wdata(wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends at a negedge; response captured one clock later
    task automatic access(input logic [1:0] k, input logic [AW-1:0] b,
                          input logic [DW-1:0] d, input logic [63:0] w);
        req_valid = 1'b1; req_kind = k; base = b; disp = d; wdata = w;
        @(negedge clk);
        got_v = rsp_valid; got_e = rsp_err; got_d = rsp_data;
        req_valid = 1'b0;
        check("R7 response valid", {63'd0, got_v}, 64'd1);
    endtask

    task automatic t_reset;
        check("R1 reset valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 reset err", {63'd0, rsp_err}, 64'd0);
        check("R1 reset data", rsp_data, 64'd0);
    endtask

    task automatic t_roundtrip;
        access(2'b11, 64'h40, 9'd0, PAT);
        check("R9 store data zero", got_d, 64'd0);
        access(2'b10, 64'h40, 9'd0, 64'd0);
        check("R3 dword readback", got_d, PAT);
        check("R3 no err", {63'd0, got_e}, 64'd0);
        for (int k = 0; k < 8; k++) begin
            access(2'b00, 64'h40, DW'(k), 64'd0);
            check("R4 byte lane zero-ext", got_d, (PAT >> (8*k)) & 64'hFF);
            check("R8 byte no err", {63'd0, got_e}, 64'd0);
        end
    endtask

    task automatic t_offsets;
        access(2'b10, 64'h48, 9'h1F8, 64'd0);
        check("R2 negative disp", got_d, PAT);
        access(2'b10, 64'h140, 9'h100, 64'd0);
        check("R2 disp -256 wraps", got_d, PAT);
        access(2'b01, 64'h1, 9'd255, 64'hAAAA_AAAA_AAAA_AA77);
        access(2'b00, 64'h0, 9'd0, 64'd0);
        check("R2 disp +255 wrap to row 0", got_d, 64'h77);
    endtask

    task automatic t_byte_store;
        access(2'b11, 64'h20, 9'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        access(2'b01, 64'h20, 9'd3, 64'h1234_5678_9ABC_DE5A);
        check("R9 byte store data zero", got_d, 64'd0);
        check("R8 byte store no err", {63'd0, got_e}, 64'd0);
        access(2'b10, 64'h20, 9'd0, 64'd0);
        check("R5 single lane written", got_d, 64'hFFFF_FFFF_5AFF_FFFF);
        access(2'b01, 64'h27, 9'd0, 64'h00);
        access(2'b10, 64'h20, 9'd0, 64'd0);
        check("R5 top lane written", got_d, 64'h00FF_FFFF_5AFF_FFFF);
    endtask

    task automatic t_misalign;
        access(2'b11, 64'h40, 9'd3, 64'hDEAD_BEEF_DEAD_BEEF);
        check("R6 store err", {63'd0, got_e}, 64'd1);
        check("R9 misaligned store data", got_d, 64'd0);
        access(2'b10, 64'h40, 9'd0, 64'd0);
        check("R6 row unchanged", got_d, PAT);
        access(2'b10, 64'h48, 9'h1FF, 64'd0);
        check("R6 load err", {63'd0, got_e}, 64'd1);
        check("R6 load data zero", got_d, 64'd0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R7 idle no response", {63'd0, rsp_valid}, 64'd0);
        check("R1 idle data zero", rsp_data, 64'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_roundtrip();
        t_offsets();
        t_byte_store();
        t_misalign();
        t_idle();
        finish_run();
    end

    initial begin
        #2000000;
        applied++;
        bad++;
        $display("FAIL R7 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end
endmodule